// File: doc/BRIEF.md
# Single-Wire Byte Bus Master

This block is the master side of a single-wire, open-drain serial bus of the kind used by battery fuel gauges. Software loads a byte, picks a direction and sets a start bit. In write direction the controller shifts the byte onto the wire. In read direction it shifts the byte out as a command and then samples an eight-bit answer from the device, all in one started operation. A separate break (initialization) pulse can be issued to resynchronise the device.

Every bit occupies one fixed-length slot. The slot starts with a low strobe whose length carries the value, and bits travel least-significant first. The wire is only ever pulled low, through an output enable; the pull-up is external. Completion is reported through status flags that clear on read and through start and break bits that clear themselves. Both behaviours depend on the interrupt-enable bit. A level interrupt is the OR of the flags, gated by that enable. A soft reset returns the registers and the bit engine to their idle state.

Top module: `swb_master`

## Requirements
- R1: After reset, offset 0x00 reads {REV_MAJOR in bits 7:4, REV_MINOR in bits 3:0}. Offsets 0x0C (control) and 0x10 (flags) read 0x00, offset 0x18 bit 0 (reset done) reads 1, and `line_oe_o` is 0.
- R2: Writing control with start (bit 4) and clock enable (bit 5) set and direction (bit 1) at 0 sends the byte at offset 0x04 as eight slots of SLOT_CYC cycles, least-significant bit first.
- R3: Each slot begins with a low strobe of exactly LOW1_CYC cycles for a 1 or LOW0_CYC cycles for a 0. The line is released for the rest of the slot and whenever the engine is idle.
- R4: When a write finishes with interrupt enable (control bit 6) set, the transmit-done flag (offset 0x10 bit 2) sets and the start bit then reads 0.
- R5: With interrupt enable set, a read of offset 0x10 returns the flags and clears them. `irq_o` is high exactly while interrupt enable is set and any flag is set.
- R6: With direction 1, the command byte is sent and then eight reply bits are received. Each reply bit is sampled RX_SMP_CYC cycles after the device pulls the line low (a high sample is a 1). The reply appears LSB first at offset 0x08, and flag bits 2 and 1 are both set.
- R7: If no falling edge from the device arrives within RX_WIN_CYC cycles during a receive, the receive is abandoned, the timeout flag (bit 0) sets and the start bit clears.
- R8: Writing control with break (bit 2) and start set drives the line low for BRK_LOW_CYC cycles and releases it for BRK_REC_CYC cycles. The timeout flag then sets, and break and start read 0.
- R9: While interrupt enable is 0, start and break do not clear after completion, a read of offset 0x10 leaves the flags set, and `irq_o` stays low. Setting interrupt enable later clears start.
- R10: A start written with clock enable 0 is ignored: start reads 0 and the line stays released.
- R11: Writing offset 0x14 with bit 1 set holds offset 0x18 bit 0 at 0 for SRST_CYC cycles, then returns it to 1. Control, flags, transmit data and configuration read 0 afterwards.
- R12: Control bits 6, 5, 1 and 0 read back as written. Configuration bit 0 (auto-idle) reads back, and configuration bit 1 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Register byte offset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (clears flags at offset 0x10) |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational from `addr_i` |
| irq_o | output | 1 | Level interrupt |
| line_i | input | 1 | Sensed level of the bus wire |
| line_oe_o | output | 1 | Pull the bus wire low when 1 |

## Verification
The bench builds the block with a 40-cycle slot, 8- and 24-cycle strobes, a 60-cycle break, a 100-cycle receive window, a 16-cycle sample point and an 8-cycle soft reset. With these values a complete write, command-plus-reply read, timeout or break takes only a few hundred cycles. Strobe widths and the break length are therefore measured to the exact cycle. A device model answers on the wire with short and long pulls, and the receive window is reached simply by staying silent.

// File: rtl/swb_pkg.sv
package swb_pkg;
  // register byte offsets
  localparam int unsigned OFS_REV = 'h00;
  localparam int unsigned OFS_TXD = 'h04;
  localparam int unsigned OFS_RXD = 'h08;
  localparam int unsigned OFS_CTL = 'h0C;
  localparam int unsigned OFS_FLG = 'h10;
  localparam int unsigned OFS_CFG = 'h14;
  localparam int unsigned OFS_STA = 'h18;

  // control bits
  localparam int unsigned CTL_IE   = 6;
  localparam int unsigned CTL_CE   = 5;
  localparam int unsigned CTL_GO   = 4;
  localparam int unsigned CTL_BRK  = 2;
  localparam int unsigned CTL_DIR  = 1;
  localparam int unsigned CTL_MODE = 0;

  // flag bits
  localparam int unsigned FLG_TX  = 2;
  localparam int unsigned FLG_RX  = 1;
  localparam int unsigned FLG_TMO = 0;

  // config bits
  localparam int unsigned CFG_SRST = 1;
  localparam int unsigned CFG_IDLE = 0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TX_LO,
    ST_TX_HI,
    ST_RX_WAIT,
    ST_RX_SMP,
    ST_RX_REL,
    ST_BRK_LO,
    ST_BRK_HI
  } eng_st_e;
endpackage

// File: rtl/swb_sync.sv
module swb_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= RST_VAL;
        else         chain_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/swb_engine.sv
module swb_engine
  import swb_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SLOT_CYC    = 1900,
  parameter int unsigned LOW1_CYC    = 300,
  parameter int unsigned LOW0_CYC    = 1000,
  parameter int unsigned BRK_LOW_CYC = 19000,
  parameter int unsigned BRK_REC_CYC = 5000,
  parameter int unsigned RX_WIN_CYC  = 32000,
  parameter int unsigned RX_SMP_CYC  = 650,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              start_i,
  input  logic              brk_i,
  input  logic              dir_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              line_i,
  output logic              line_oe_o,
  output logic              tx_done_o,
  output logic              rx_done_o,
  output logic              tmo_o,
  output logic              end_o,
  output logic [DATA_W-1:0] rx_byte_o
);
  localparam int unsigned MAX_A = (SLOT_CYC > BRK_LOW_CYC) ? SLOT_CYC : BRK_LOW_CYC;
  localparam int unsigned MAX_B = (RX_WIN_CYC > BRK_REC_CYC) ? RX_WIN_CYC : BRK_REC_CYC;
  localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W = $clog2(MAX_C + 1);
  localparam int unsigned BIT_W = $clog2(DATA_W);

  eng_st_e           st_q;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt, lo_end, hi_end;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] sh_q, rx_sh_q;
  logic              rd_q, oe_q, line_s, last_bit;
  logic              txd_p, rxd_p, tmo_p, end_p;

  swb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  assign cnt_nxt  = cnt_q + 1'b1;
  assign lo_end   = sh_q[0] ? CNT_W'(LOW1_CYC - 1) : CNT_W'(LOW0_CYC - 1);
  assign hi_end   = sh_q[0] ? CNT_W'(SLOT_CYC - LOW1_CYC - 1) : CNT_W'(SLOT_CYC - LOW0_CYC - 1);
  assign last_bit = (bit_q == BIT_W'(DATA_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      rx_sh_q <= '0;
      rd_q    <= 1'b0;
      oe_q    <= 1'b0;
      txd_p   <= 1'b0;
      rxd_p   <= 1'b0;
      tmo_p   <= 1'b0;
      end_p   <= 1'b0;
    end else begin
      txd_p <= 1'b0;
      rxd_p <= 1'b0;
      tmo_p <= 1'b0;
      end_p <= 1'b0;
      if (srst_i) begin
        st_q    <= ST_IDLE;
        cnt_q   <= '0;
        bit_q   <= '0;
        sh_q    <= '0;
        rx_sh_q <= '0;
        rd_q    <= 1'b0;
        oe_q    <= 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE: if (start_i) begin
            cnt_q <= '0;
            bit_q <= '0;
            oe_q  <= 1'b1;
            if (brk_i) begin
              st_q <= ST_BRK_LO;
            end else begin
              st_q <= ST_TX_LO;
              sh_q <= tx_byte_i;
              rd_q <= dir_i;
            end
          end
          ST_TX_LO: begin
            if (cnt_q == lo_end) begin
              cnt_q <= '0;
              oe_q  <= 1'b0;
              st_q  <= ST_TX_HI;
            end else cnt_q <= cnt_nxt;
          end
          ST_TX_HI: begin
            if (cnt_q == hi_end) begin
              cnt_q <= '0;
              sh_q  <= sh_q >> 1;
              if (last_bit) begin
                txd_p <= 1'b1;
                bit_q <= '0;
                if (rd_q) st_q <= ST_RX_WAIT;
                else begin
                  end_p <= 1'b1;
                  st_q  <= ST_IDLE;
                end
              end else begin
                bit_q <= bit_q + 1'b1;
                oe_q  <= 1'b1;
                st_q  <= ST_TX_LO;
              end
            end else cnt_q <= cnt_nxt;
          end
          ST_RX_WAIT: begin
            if (!line_s) begin
              cnt_q <= '0;
              st_q  <= ST_RX_SMP;
            end else if (cnt_q == CNT_W'(RX_WIN_CYC - 1)) begin
              tmo_p <= 1'b1;
              end_p <= 1'b1;
              st_q  <= ST_IDLE;
            end else cnt_q <= cnt_nxt;
          end
          ST_RX_SMP: begin
            if (cnt_q == CNT_W'(RX_SMP_CYC - 1)) begin
              cnt_q   <= '0;
              rx_sh_q <= {line_s, rx_sh_q[DATA_W-1:1]};
              st_q    <= ST_RX_REL;
            end else cnt_q <= cnt_nxt;
          end
          ST_RX_REL: begin
            if (line_s) begin
              cnt_q <= '0;
              if (last_bit) begin
                rxd_p <= 1'b1;
                end_p <= 1'b1;
                st_q  <= ST_IDLE;
              end else begin
                bit_q <= bit_q + 1'b1;
                st_q  <= ST_RX_WAIT;
              end
            end else if (cnt_q == CNT_W'(RX_WIN_CYC - 1)) begin
              tmo_p <= 1'b1;
              end_p <= 1'b1;
              st_q  <= ST_IDLE;
            end else cnt_q <= cnt_nxt;
          end
          ST_BRK_LO: begin
            if (cnt_q == CNT_W'(BRK_LOW_CYC - 1)) begin
              cnt_q <= '0;
              oe_q  <= 1'b0;
              st_q  <= ST_BRK_HI;
            end else cnt_q <= cnt_nxt;
          end
          ST_BRK_HI: begin
            if (cnt_q == CNT_W'(BRK_REC_CYC - 1)) begin
              cnt_q <= '0;
              tmo_p <= 1'b1;
              end_p <= 1'b1;
              st_q  <= ST_IDLE;
            end else cnt_q <= cnt_nxt;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign line_oe_o = oe_q;
  assign tx_done_o = txd_p;
  assign rx_done_o = rxd_p;
  assign tmo_o     = tmo_p;
  assign end_o     = end_p;
  assign rx_byte_o = rx_sh_q;

  assert_start_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (st_q == ST_IDLE));

  assert_release_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !line_oe_o);

  assert_rx_tmo_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rx_done_o, tmo_o}));

  assert_tmo_released_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |-> !line_oe_o);
endmodule

// File: rtl/swb_regs.sv
module swb_regs
  import swb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned REV_MAJOR = 1,
  parameter int unsigned REV_MINOR = 0,
  parameter int unsigned SRST_CYC  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              srst_o,
  output logic              start_o,
  output logic              brk_o,
  output logic              dir_o,
  output logic [DATA_W-1:0] tx_byte_o,
  input  logic              tx_done_i,
  input  logic              rx_done_i,
  input  logic              tmo_i,
  input  logic              end_i,
  input  logic [DATA_W-1:0] rx_byte_i
);
  localparam int unsigned SRST_W = $clog2(SRST_CYC + 1);
  localparam logic [DATA_W-1:0] CTL_RW = DATA_W'((1 << CTL_IE) | (1 << CTL_CE) |
                                                 (1 << CTL_DIR) | (1 << CTL_MODE));
  localparam logic [DATA_W-1:0] CFG_RW = DATA_W'(1 << CFG_IDLE);

  logic [DATA_W-1:0] ctl_q, cfg_q, txd_q, rxd_q;
  logic [2:0]        flg_q, flg_set;
  logic              go_q, brk_q, pend_q;
  logic [SRST_W-1:0] srst_cnt_q;
  logic              srst_act, hit_ctl, hit_flg, hit_cfg, hit_txd;
  logic              wr_ctl, flg_clr, ie;

  assign srst_act = (srst_cnt_q != '0);
  assign hit_ctl  = (addr_i == ADDR_W'(OFS_CTL));
  assign hit_flg  = (addr_i == ADDR_W'(OFS_FLG));
  assign hit_cfg  = (addr_i == ADDR_W'(OFS_CFG));
  assign hit_txd  = (addr_i == ADDR_W'(OFS_TXD));
  assign ie       = ctl_q[CTL_IE];
  assign wr_ctl   = wr_i && hit_ctl && !srst_act;
  assign start_o  = wr_ctl && !go_q && wdata_i[CTL_GO] && wdata_i[CTL_CE];
  assign brk_o    = wdata_i[CTL_BRK];
  assign dir_o    = wdata_i[CTL_DIR];
  assign flg_clr  = rd_i && hit_flg && ie;
  assign flg_set  = {tx_done_i, rx_done_i, tmo_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q      <= '0;
      cfg_q      <= '0;
      txd_q      <= '0;
      rxd_q      <= '0;
      flg_q      <= '0;
      go_q       <= 1'b0;
      brk_q      <= 1'b0;
      pend_q     <= 1'b0;
      srst_cnt_q <= '0;
    end else if (srst_act) begin
      ctl_q      <= '0;
      cfg_q      <= '0;
      txd_q      <= '0;
      rxd_q      <= '0;
      flg_q      <= '0;
      go_q       <= 1'b0;
      brk_q      <= 1'b0;
      pend_q     <= 1'b0;
      srst_cnt_q <= srst_cnt_q - 1'b1;
    end else begin
      flg_q <= (flg_clr ? 3'b000 : flg_q) | flg_set;
      if (rx_done_i) rxd_q <= rx_byte_i;
      if (end_i) pend_q <= 1'b1;
      if (wr_i && hit_txd) txd_q <= wdata_i;
      if (wr_i && hit_cfg) begin
        cfg_q <= wdata_i & CFG_RW;
        if (wdata_i[CFG_SRST]) srst_cnt_q <= SRST_W'(SRST_CYC);
      end
      if (wr_ctl) begin
        ctl_q <= wdata_i & CTL_RW;
        if (!go_q) begin
          go_q  <= start_o;
          brk_q <= start_o && wdata_i[CTL_BRK];
        end
      end
      // start and break self-clear only once interrupts are enabled
      if (go_q && pend_q && ie) begin
        go_q   <= 1'b0;
        brk_q  <= 1'b0;
        pend_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(OFS_REV): rdata_o = DATA_W'({4'(REV_MAJOR), 4'(REV_MINOR)});
      ADDR_W'(OFS_TXD): rdata_o = txd_q;
      ADDR_W'(OFS_RXD): rdata_o = rxd_q;
      ADDR_W'(OFS_CTL): begin
        rdata_o = ctl_q;
        rdata_o[CTL_GO]  = go_q;
        rdata_o[CTL_BRK] = brk_q;
      end
      ADDR_W'(OFS_FLG): rdata_o = DATA_W'(flg_q);
      ADDR_W'(OFS_CFG): rdata_o = cfg_q;
      ADDR_W'(OFS_STA): rdata_o = DATA_W'(!srst_act);
      default:          rdata_o = '0;
    endcase
  end

  assign irq_o     = ie && (flg_q != 3'b000);
  assign srst_o    = srst_act;
  assign tx_byte_o = txd_q;

  assert_flag_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flg_clr && !srst_act && (flg_set == 3'b000)) |=> (flg_q == 3'b000));

  assert_go_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_q && !ie && !srst_act) |=> go_q);

  assert_ce_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctl && !go_q && !wdata_i[CTL_CE]) |=> !go_q);

  assert_srst_start_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit_cfg && wdata_i[CFG_SRST] && !srst_act) |=> (rdata_o == '0 || addr_i != ADDR_W'(OFS_STA)));
endmodule

// File: rtl/swb_master.sv
module swb_master #(
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned REV_MAJOR   = 1,
  parameter int unsigned REV_MINOR   = 2,
  parameter int unsigned SLOT_CYC    = 1900,
  parameter int unsigned LOW1_CYC    = 300,
  parameter int unsigned LOW0_CYC    = 1000,
  parameter int unsigned BRK_LOW_CYC = 19000,
  parameter int unsigned BRK_REC_CYC = 5000,
  parameter int unsigned RX_WIN_CYC  = 32000,
  parameter int unsigned RX_SMP_CYC  = 650,
  parameter int unsigned SRST_CYC    = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  input  logic              line_i,
  output logic              line_oe_o
);
  logic              srst, start, brk, dir, tx_done, rx_done, tmo, eng_end;
  logic [DATA_W-1:0] tx_byte, rx_byte;

  swb_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .REV_MAJOR(REV_MAJOR),
    .REV_MINOR(REV_MINOR),
    .SRST_CYC (SRST_CYC)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .irq_o    (irq_o),
    .srst_o   (srst),
    .start_o  (start),
    .brk_o    (brk),
    .dir_o    (dir),
    .tx_byte_o(tx_byte),
    .tx_done_i(tx_done),
    .rx_done_i(rx_done),
    .tmo_i    (tmo),
    .end_i    (eng_end),
    .rx_byte_i(rx_byte)
  );

  swb_engine #(
    .DATA_W     (DATA_W),
    .SLOT_CYC   (SLOT_CYC),
    .LOW1_CYC   (LOW1_CYC),
    .LOW0_CYC   (LOW0_CYC),
    .BRK_LOW_CYC(BRK_LOW_CYC),
    .BRK_REC_CYC(BRK_REC_CYC),
    .RX_WIN_CYC (RX_WIN_CYC),
    .RX_SMP_CYC (RX_SMP_CYC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_engine (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .srst_i   (srst),
    .start_i  (start),
    .brk_i    (brk),
    .dir_i    (dir),
    .tx_byte_i(tx_byte),
    .line_i   (line_i),
    .line_oe_o(line_oe_o),
    .tx_done_o(tx_done),
    .rx_done_o(rx_done),
    .tmo_o    (tmo),
    .end_o    (eng_end),
    .rx_byte_o(rx_byte)
  );

  assert_srst_release_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> !line_oe_o);
endmodule

// File: tb/swb_master_tb.sv
module swb_master_tb;
  localparam int SLOT = 40, LOW1 = 8, LOW0 = 24, BRKL = 60, BRKR = 20;
  localparam int RXW = 100, RXS = 16, SRST = 8;
  localparam logic [4:0] A_REV = 5'h00, A_TXD = 5'h04, A_RXD = 5'h08, A_CTL = 5'h0C;
  localparam logic [4:0] A_FLG = 5'h10, A_CFG = 5'h14, A_STA = 5'h18;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [4:0] addr_i = '0;
  logic       wr_i = 1'b0, rd_i = 1'b0, dev_pull = 1'b0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic       irq_o, line_oe_o, line_i;
  int         n_chk = 0, n_err = 0;

  always #10 clk_i = ~clk_i;
  assign line_i = ~(line_oe_o | dev_pull);

  swb_master #(
    .REV_MAJOR(3), .REV_MINOR(7), .SLOT_CYC(SLOT), .LOW1_CYC(LOW1), .LOW0_CYC(LOW0),
    .BRK_LOW_CYC(BRKL), .BRK_REC_CYC(BRKR), .RX_WIN_CYC(RXW), .RX_SMP_CYC(RXS),
    .SRST_CYC(SRST)
  ) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .line_i(line_i),
    .line_oe_o(line_oe_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk_i); addr_i = a; rd_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i); rd_i = 1'b0;
  endtask

  task automatic measure_low(output int w);
    do @(negedge clk_i); while (line_oe_o !== 1'b1);
    w = 0;
    while (line_oe_o === 1'b1) begin w++; @(negedge clk_i); end
  endtask

  task automatic watch_tx(output logic [7:0] b, output int bad);
    int w;
    bad = 0; b = '0;
    for (int i = 0; i < 8; i++) begin
      measure_low(w);
      if (w == LOW1) b[i] = 1'b1;
      else if (w == LOW0) b[i] = 1'b0;
      else bad++;
    end
  endtask

  task automatic dev_reply(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      do @(negedge clk_i); while (line_oe_o !== 1'b1);
      do @(negedge clk_i); while (line_oe_o === 1'b1);
    end
    repeat (40) @(negedge clk_i);
    for (int i = 0; i < 8; i++) begin
      dev_pull = 1'b1;
      repeat (v[i] ? 8 : 28) @(negedge clk_i);
      dev_pull = 1'b0;
      repeat (v[i] ? 40 : 20) @(negedge clk_i);
    end
  endtask

  task automatic wait_idle();
    logic [7:0] d;
    for (int i = 0; i < 2000; i++) begin
      bus_rd(A_CTL, d);
      if (!d[4]) break;
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 line released", line_oe_o, 0);
    bus_rd(A_REV, d); chk("R1 revision", d, 8'h37);
    bus_rd(A_CTL, d); chk("R1 control", d, 8'h00);
    bus_rd(A_FLG, d); chk("R1 flags", d, 8'h00);
    bus_rd(A_STA, d); chk("R1 reset done", d, 8'h01);
  endtask

  task automatic t_write();
    logic [7:0] b, d; int bad;
    bus_wr(A_TXD, 8'hA5);
    fork
      bus_wr(A_CTL, 8'h70);
      watch_tx(b, bad);
    join
    chk("R2 byte on wire", b, 8'hA5);
    chk("R3 strobe widths", bad, 0);
    wait_idle();
    chk("R5 irq raised", irq_o, 1);
    bus_rd(A_CTL, d); chk("R4 start cleared", d, 8'h60);
    bus_rd(A_FLG, d); chk("R4 tx flag", d, 8'h04);
    bus_rd(A_FLG, d); chk("R5 flags cleared", d, 8'h00);
    chk("R5 irq dropped", irq_o, 0);
  endtask

  task automatic t_read();
    logic [7:0] b, d; int bad;
    bus_wr(A_TXD, 8'h3C);
    fork
      bus_wr(A_CTL, 8'h72);
      watch_tx(b, bad);
      dev_reply(8'h96);
    join
    chk("R6 command byte", b, 8'h3C);
    wait_idle();
    bus_rd(A_FLG, d); chk("R6 tx and rx flags", d, 8'h06);
    bus_rd(A_RXD, d); chk("R6 reply byte", d, 8'h96);
  endtask

  task automatic t_read_tmo();
    logic [7:0] b, d; int bad;
    bus_wr(A_TXD, 8'h11);
    fork
      bus_wr(A_CTL, 8'h72);
      watch_tx(b, bad);
    join
    wait_idle();
    bus_rd(A_CTL, d); chk("R7 start cleared", d, 8'h62);
    bus_rd(A_FLG, d); chk("R7 timeout flag", d, 8'h05);
  endtask

  task automatic t_break();
    logic [7:0] d; int w;
    fork
      bus_wr(A_CTL, 8'h74);
      measure_low(w);
    join
    chk("R8 break width", w, BRKL);
    wait_idle();
    bus_rd(A_CTL, d); chk("R8 break and start cleared", d, 8'h60);
    bus_rd(A_FLG, d); chk("R8 timeout flag", d, 8'h01);
  endtask

  task automatic t_no_ie();
    logic [7:0] b, d; int bad;
    bus_wr(A_TXD, 8'h5A);
    fork
      bus_wr(A_CTL, 8'h30);
      watch_tx(b, bad);
    join
    repeat (60) @(negedge clk_i);
    bus_rd(A_CTL, d); chk("R9 start held", d, 8'h30);
    chk("R9 irq masked", irq_o, 0);
    bus_rd(A_FLG, d); chk("R9 flags read", d, 8'h04);
    bus_rd(A_FLG, d); chk("R9 flags kept", d, 8'h04);
    bus_wr(A_CTL, 8'h60);
    repeat (3) @(negedge clk_i);
    bus_rd(A_CTL, d); chk("R9 start cleared after enable", d, 8'h60);
    chk("R9 irq after enable", irq_o, 1);
    bus_rd(A_FLG, d);
    bus_rd(A_FLG, d); chk("R9 flags cleared after enable", d, 8'h00);
  endtask

  task automatic t_no_ce();
    logic [7:0] d; int seen;
    seen = 0;
    bus_wr(A_CTL, 8'h50);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_i);
      if (line_oe_o) seen++;
    end
    chk("R10 line idle", seen, 0);
    bus_rd(A_CTL, d); chk("R10 start ignored", d, 8'h40);
  endtask

  task automatic t_cfg_srst();
    logic [7:0] d;
    bus_wr(A_CTL, 8'h61);
    bus_rd(A_CTL, d); chk("R12 control readback", d, 8'h61);
    bus_wr(A_CFG, 8'h01);
    bus_rd(A_CFG, d); chk("R12 auto-idle readback", d, 8'h01);
    bus_wr(A_TXD, 8'hC3);
    bus_wr(A_CFG, 8'h02);
    bus_rd(A_STA, d); chk("R11 reset busy", d, 8'h00);
    repeat (SRST + 4) @(negedge clk_i);
    bus_rd(A_STA, d); chk("R11 reset done", d, 8'h01);
    bus_rd(A_CTL, d); chk("R11 control cleared", d, 8'h00);
    bus_rd(A_TXD, d); chk("R11 tx data cleared", d, 8'h00);
    bus_rd(A_CFG, d); chk("R12 reset bit reads 0", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_write();
    t_read();
    t_read_tmo();
    t_break();
    t_no_ie();
    t_no_ce();
    t_cfg_srst();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule